// File: doc/BRIEF.md
# Flash Program and Erase Sequencer

This block sits between a small register bus and an on-chip flash macro and turns software register writes into page erase and word program operations. Software loads a byte address, then sets a start bit for erase, for write, or for both. For a write sequence it supplies 32-bit words one at a time through a single-word buffer. The sequencer checks the page lock for every operation and reports a refused operation through an abort flag. It steps the word address after each programmed word. A write sequence closes by itself once no new word arrives within a parameterised number of cycles.

Three registers are decoded by `bus_idx`: 0 is control/status, 1 is address, 2 is write data. Reads are combinational. Control bits: 0 erase start, 1 write start, [3:2] cache mode, 5 abort, 6 buffer full, 7 busy, 8 information-page select, 9 top-page enable. The block also holds a two-bit cache-mode field. A new value for it is handed to the read path through a request/ready handshake.

The controller is one state machine. `ST_IDLE` waits for a start. `ST_ER_CHK` checks the lock on the erase page. `ST_ER_RUN` holds the erase request until the macro reports done. `ST_WR_WAIT` waits for a data word and runs the timeout. `ST_WR_CHK` checks the lock for the buffered word. `ST_WR_RUN` holds the program request until done. Transitions:
- IDLE→ER_CHK when erase is started.
- IDLE→WR_WAIT when only write is started.
- ER_CHK→ER_RUN if the page is unlocked. If it is locked, ER_CHK goes to WR_WAIT when a write is chained, otherwise to IDLE.
- ER_RUN→WR_WAIT or IDLE on done.
- WR_WAIT→WR_CHK when the buffer is full.
- WR_WAIT→IDLE on timeout.
- WR_CHK→WR_RUN if unlocked, otherwise WR_CHK→IDLE.
- WR_RUN→WR_WAIT on done.

Top module: `flash_pgm_ctrl`

## Requirements
- R1: After reset the control and address registers read 0 and neither flash request is asserted.
- R2: Writing 1 to control bit 0 starts a page erase of page `addr[16:9]`. Busy (bit 7) reads 1 while erase (bit 0) or write (bit 1) is set, and the erase bit clears when the macro signals done.
- R3: Control writes made while busy are ignored entirely: start bits, information select and top enable.
- R4: When bits 0 and 1 are set in one control write, the erase completes before the first word is programmed, and the two requests are never active together.
- R5: A data write is accepted only while the write bit is 1 and full (bit 6) is 0. Acceptance sets full. Data written while idle is never programmed.
- R6: Each buffered word is programmed at the current word address, and the address then increments by one, wrapping from 0x1FFFF to 0.
- R7: An erase or write on a locked page sets abort (bit 5) and issues no flash request. A page is locked when `page_lock[page]` is 1, or when it is page 255 with top enable (bit 9) at 0. A new start clears abort.
- R8: A write sequence with no word accepted for TMO_CYC cycles ends, clearing write and busy, with abort at 0.
- R9: In a chained erase and write, abort reflects only the write phase. A locked erase followed by a timed-out write leaves abort at 0.
- R10: An address-register write stores byte address bits [18:2]; reading returns that 17-bit word address. Address writes are ignored while busy.
- R11: A write of a cache-mode value that differs from the current mode raises `cm_req` with `cm_target`. The readback mode changes only when `cm_ready` is seen, and further mode writes are ignored while a request is pending.
- R12: With information select (bit 8) set, the page lock is not checked and `fl_info` is driven high to the macro.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | Access is a write |
| bus_idx | input | 2 | Register index: 0 control, 1 address, 2 data |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_idx` |
| page_lock | input | 256 | One lock bit per main-array page |
| fl_erase_req | output | 1 | Page erase request to the macro |
| fl_prog_req | output | 1 | Word program request to the macro |
| fl_addr | output | 17 | Word address to the macro |
| fl_wdata | output | 32 | Word to program |
| fl_info | output | 1 | Operation targets the information page |
| fl_done | input | 1 | Macro operation complete pulse |
| cm_mode | output | 2 | Cache mode in effect |
| cm_req | output | 1 | Cache mode change pending |
| cm_target | output | 2 | Requested cache mode |
| cm_ready | input | 1 | Read path accepts the pending mode |

## Verification
The assertions assume that the flash macro raises `fl_done` only while a request is held, as a single-cycle pulse. They also assume that `cm_ready` means acceptance only while `cm_req` is high. The bench's behavioural flash stub keeps to this: it counts a fixed latency from the request and pulses done once. `cm_ready` is raised for a single cycle only while a change is pending. Bus accesses are driven on falling edges and held for exactly one cycle, so each register write is captured once.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ER_CHK,
        ST_ER_RUN,
        ST_WR_WAIT,
        ST_WR_CHK,
        ST_WR_RUN
    } fpc_state_t;

    localparam logic [1:0] REG_CTRL = 2'd0;
    localparam logic [1:0] REG_ADDR = 2'd1;
    localparam logic [1:0] REG_DATA = 2'd2;

    localparam int CB_ERASE = 0;
    localparam int CB_WRITE = 1;
    localparam int CB_CM_LO = 2;
    localparam int CB_ABORT = 5;
    localparam int CB_FULL  = 6;
    localparam int CB_BUSY  = 7;
    localparam int CB_INFO  = 8;
    localparam int CB_TOP   = 9;
endpackage

// File: rtl/fpc_lock_check.sv
module fpc_lock_check #(
    parameter int PAGE_W = 8
) (
    input  logic [(2**PAGE_W)-1:0] page_lock,
    input  logic [PAGE_W-1:0]      page,
    input  logic                   info_sel,
    input  logic                   top_en,
    output logic                   locked
);
    logic top_blocked;

    always_comb begin
        top_blocked = (page == '1) && !top_en;
        locked      = !info_sel && (page_lock[page] || top_blocked);
    end
endmodule

// File: rtl/fpc_timeout.sv
module fpc_timeout #(
    parameter int LIMIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart || !run) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = run && (cnt == CW'(LIMIT - 1));
endmodule

// File: rtl/fpc_cache_mode.sv
module fpc_cache_mode #(
    parameter int CM_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [CM_W-1:0] new_mode,
    input  logic            ready,
    output logic [CM_W-1:0] cur_mode,
    output logic            pending,
    output logic [CM_W-1:0] target
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_mode <= '0;
            pending  <= 1'b0;
            target   <= '0;
        end else if (pending) begin
            if (ready) begin
                cur_mode <= target;
                pending  <= 1'b0;
            end
        end else if (wr_en && (new_mode != cur_mode)) begin
            pending <= 1'b1;
            target  <= new_mode;
        end
    end
endmodule

// File: rtl/flash_pgm_ctrl.sv
module flash_pgm_ctrl
    import fpc_pkg::*;
#(
    parameter int ADDR_W  = 17,
    parameter int DATA_W  = 32,
    parameter int PAGE_W  = 8,
    parameter int CM_W    = 2,
    parameter int TMO_CYC = 64
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_sel,
    input  logic                   bus_wr,
    input  logic [1:0]             bus_idx,
    input  logic [DATA_W-1:0]      bus_wdata,
    output logic [DATA_W-1:0]      bus_rdata,
    input  logic [(2**PAGE_W)-1:0] page_lock,
    output logic                   fl_erase_req,
    output logic                   fl_prog_req,
    output logic [ADDR_W-1:0]      fl_addr,
    output logic [DATA_W-1:0]      fl_wdata,
    output logic                   fl_info,
    input  logic                   fl_done,
    output logic [CM_W-1:0]        cm_mode,
    output logic                   cm_req,
    output logic [CM_W-1:0]        cm_target,
    input  logic                   cm_ready
);
    localparam int PAGE_LSB = ADDR_W - PAGE_W;

    fpc_state_t state, state_nx;

    logic              erase_bit, write_bit, abort, full;
    logic              info_sel, top_en;
    logic [ADDR_W-1:0] waddr;
    logic [DATA_W-1:0] wbuf;
    logic              busy;
    logic              ctrl_wr, addr_wr, data_wr, data_acc;
    logic              locked, tmo_exp, tmo_hit;
    logic              erase_go, write_go;

    // ---------------------------------------------------------------
    // Bus decode
    // ---------------------------------------------------------------
    assign busy     = erase_bit || write_bit;
    assign ctrl_wr  = bus_sel && bus_wr && (bus_idx == REG_CTRL);
    assign addr_wr  = bus_sel && bus_wr && (bus_idx == REG_ADDR);
    assign data_wr  = bus_sel && bus_wr && (bus_idx == REG_DATA);
    assign data_acc = data_wr && write_bit && !full;
    assign erase_go = bus_wdata[CB_ERASE];
    assign write_go = bus_wdata[CB_WRITE];
    assign tmo_hit  = tmo_exp && !data_acc;

    fpc_lock_check #(.PAGE_W(PAGE_W)) i_lock (
        .page_lock (page_lock),
        .page      (waddr[ADDR_W-1:PAGE_LSB]),
        .info_sel  (info_sel),
        .top_en    (top_en),
        .locked    (locked)
    );

    fpc_timeout #(.LIMIT(TMO_CYC)) i_tmo (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     ((state == ST_WR_WAIT) && !full),
        .restart (data_acc),
        .expired (tmo_exp)
    );

    fpc_cache_mode #(.CM_W(CM_W)) i_cache (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (ctrl_wr),
        .new_mode (bus_wdata[CB_CM_LO +: CM_W]),
        .ready    (cm_ready),
        .cur_mode (cm_mode),
        .pending  (cm_req),
        .target   (cm_target)
    );

    // ---------------------------------------------------------------
    // Next state
    // ---------------------------------------------------------------
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (ctrl_wr && erase_go)      state_nx = ST_ER_CHK;
                else if (ctrl_wr && write_go) state_nx = ST_WR_WAIT;
            end
            ST_ER_CHK: begin
                if (!locked)        state_nx = ST_ER_RUN;
                else if (write_bit) state_nx = ST_WR_WAIT;
                else                state_nx = ST_IDLE;
            end
            ST_ER_RUN: begin
                if (fl_done) state_nx = write_bit ? ST_WR_WAIT : ST_IDLE;
            end
            ST_WR_WAIT: begin
                if (full)         state_nx = ST_WR_CHK;
                else if (tmo_hit) state_nx = ST_IDLE;
            end
            ST_WR_CHK: begin
                state_nx = locked ? ST_IDLE : ST_WR_RUN;
            end
            ST_WR_RUN: begin
                if (fl_done) state_nx = ST_WR_WAIT;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // ---------------------------------------------------------------
    // Control / status and datapath registers
    // ---------------------------------------------------------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            erase_bit <= 1'b0;
            write_bit <= 1'b0;
            abort     <= 1'b0;
            full      <= 1'b0;
            info_sel  <= 1'b0;
            top_en    <= 1'b0;
            waddr     <= '0;
            wbuf      <= '0;
        end else begin
            if (ctrl_wr && !busy) begin
                info_sel  <= bus_wdata[CB_INFO];
                top_en    <= bus_wdata[CB_TOP];
                erase_bit <= erase_go;
                write_bit <= write_go;
                if (erase_go || write_go) abort <= 1'b0;
            end
            if (addr_wr && !busy) begin
                waddr <= bus_wdata[ADDR_W+1:2];
            end
            if (data_acc) begin
                full <= 1'b1;
                wbuf <= bus_wdata;
            end
            unique case (state)
                ST_ER_CHK: begin
                    if (locked) begin
                        erase_bit <= 1'b0;
                        abort     <= !write_bit;
                    end
                end
                ST_ER_RUN: begin
                    if (fl_done) begin
                        erase_bit <= 1'b0;
                        if (write_bit) abort <= 1'b0;
                    end
                end
                ST_WR_WAIT: begin
                    if (!full && tmo_hit) write_bit <= 1'b0;
                end
                ST_WR_CHK: begin
                    if (locked) begin
                        abort     <= 1'b1;
                        full      <= 1'b0;
                        write_bit <= 1'b0;
                    end
                end
                ST_WR_RUN: begin
                    if (fl_done) begin
                        full  <= 1'b0;
                        waddr <= waddr + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // ---------------------------------------------------------------
    // Outputs
    // ---------------------------------------------------------------
    always_comb begin
        fl_erase_req = (state == ST_ER_RUN);
        fl_prog_req  = (state == ST_WR_RUN);
        fl_addr      = waddr;
        fl_wdata     = wbuf;
        fl_info      = info_sel;
        bus_rdata    = '0;
        unique case (bus_idx)
            REG_CTRL: begin
                bus_rdata[CB_ERASE]            = erase_bit;
                bus_rdata[CB_WRITE]            = write_bit;
                bus_rdata[CB_CM_LO +: CM_W]    = cm_mode;
                bus_rdata[CB_ABORT]            = abort;
                bus_rdata[CB_FULL]             = full;
                bus_rdata[CB_BUSY]             = busy;
                bus_rdata[CB_INFO]             = info_sel;
                bus_rdata[CB_TOP]              = top_en;
            end
            REG_ADDR: bus_rdata = DATA_W'(waddr);
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/fpc_checker.sv
module fpc_checker #(
    parameter int ADDR_W = 17,
    parameter int CM_W   = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fl_erase_req,
    input logic              fl_prog_req,
    input logic              fl_done,
    input logic [ADDR_W-1:0] waddr,
    input logic              busy,
    input logic              addr_wr,
    input logic              abort,
    input logic              full,
    input logic              write_bit,
    input logic [CM_W-1:0]   cm_mode,
    input logic              cm_ready
);
    // R2
    erase_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fl_erase_req |-> busy);

    // R4
    req_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(fl_erase_req && fl_prog_req));

    // R5
    full_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(full) |-> write_bit);

    // R6
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_prog_req && fl_done) |=> (waddr == ADDR_W'($past(waddr) + 1'b1)));

    // R7
    abort_noreq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(abort) |-> (!fl_erase_req && !fl_prog_req));

    // R10
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && addr_wr && !fl_prog_req) |=> $stable(waddr));

    // R11
    cm_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cm_ready |=> $stable(cm_mode));
endmodule

bind flash_pgm_ctrl fpc_checker #(.ADDR_W(ADDR_W), .CM_W(CM_W)) i_fpc_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .fl_erase_req (fl_erase_req),
    .fl_prog_req  (fl_prog_req),
    .fl_done      (fl_done),
    .waddr        (waddr),
    .busy         (busy),
    .addr_wr      (addr_wr),
    .abort        (abort),
    .full         (full),
    .write_bit    (write_bit),
    .cm_mode      (cm_mode),
    .cm_ready     (cm_ready)
);

// File: tb/test_flash_pgm_ctrl.sv
`timescale 1ns/1ps
module test_flash_pgm_ctrl;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_sel = 1'b0, bus_wr = 1'b0;
    logic [1:0]   bus_idx = 2'd0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic [255:0] page_lock = '0;
    logic         fl_erase_req, fl_prog_req, fl_info;
    logic [16:0]  fl_addr;
    logic [31:0]  fl_wdata;
    logic         fl_done = 1'b0;
    logic [1:0]   cm_mode, cm_target;
    logic         cm_req;
    logic         cm_ready = 1'b0;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    flash_pgm_ctrl i_flash_pgm_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_idx(bus_idx), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .page_lock(page_lock), .fl_erase_req(fl_erase_req),
        .fl_prog_req(fl_prog_req), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
        .fl_info(fl_info), .fl_done(fl_done), .cm_mode(cm_mode),
        .cm_req(cm_req), .cm_target(cm_target), .cm_ready(cm_ready)
    );

    // behavioural flash stub
    int          lat_cnt = 0, ev_seq = 0;
    int          n_erase = 0, n_prog = 0, erase_at = 0, prog_at = 0;
    logic [7:0]  last_page = '0;
    logic        last_info = 1'b0;
    logic [16:0] last_paddr = '0;
    logic [31:0] prog_log [8];

    always @(posedge clk) begin
        if ((fl_erase_req || fl_prog_req) && !fl_done) begin
            if (lat_cnt == 3) begin
                fl_done <= 1'b1;
                lat_cnt <= 0;
                ev_seq  <= ev_seq + 1;
                if (fl_erase_req) begin
                    n_erase   <= n_erase + 1;
                    last_page <= fl_addr[16:9];
                    last_info <= fl_info;
                    erase_at  <= ev_seq + 1;
                end else begin
                    prog_log[n_prog % 8] <= fl_wdata;
                    n_prog     <= n_prog + 1;
                    last_paddr <= fl_addr;
                    prog_at    <= ev_seq + 1;
                end
            end else begin
                lat_cnt <= lat_cnt + 1;
                fl_done <= 1'b0;
            end
        end else begin
            fl_done <= 1'b0;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] idx, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_idx = idx; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_idx = 2'd0;
    endtask

    task automatic bus_read(input logic [1:0] idx, output logic [31:0] d);
        bus_idx = idx;
        #1 d = bus_rdata;
        bus_idx = 2'd0;
    endtask

    task automatic wait_idle();
        logic [31:0] r;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            bus_read(2'd0, r);
            if (!r[7]) break;
        end
    endtask

    task automatic wait_prog(input int n);
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (n_prog >= n) break;
        end
    endtask

    task automatic t_reset();
        logic [31:0] r;
        bus_read(2'd0, r); chk("R1 ctrl", r, 32'h0);
        bus_read(2'd1, r); chk("R1 addr", r, 32'h0);
        chk("R1 reqs", {fl_erase_req, fl_prog_req}, 32'h0);
    endtask

    task automatic t_addr();
        logic [31:0] r;
        bus_write(2'd1, 32'h0001_2344);
        bus_read(2'd1, r); chk("R10 addr readback", r, 32'h48D1);
    endtask

    task automatic t_erase();
        logic [31:0] r;
        int e0 = n_erase;
        bus_write(2'd1, 32'h2800);            // page 5
        bus_write(2'd0, 32'h1);
        bus_read(2'd0, r); chk("R2 busy set", r & 32'h81, 32'h81);
        bus_write(2'd0, 32'h302);              // ignored while busy
        bus_write(2'd1, 32'h4000);             // ignored while busy
        wait_idle();
        chk("R2 erase count", n_erase, e0 + 1);
        chk("R2 erase page", last_page, 32'd5);
        bus_read(2'd0, r); chk("R3 ctrl after busy write", r, 32'h0);
        bus_read(2'd1, r); chk("R10 addr held while busy", r, 32'hA00);
    endtask

    task automatic t_write();
        logic [31:0] r;
        int p0 = n_prog;
        bus_write(2'd2, 32'h1111);             // idle: ignored
        bus_write(2'd1, 32'h3000);             // page 6 word 0
        bus_write(2'd0, 32'h2);
        bus_read(2'd0, r); chk("R5 full clear after idle data", r & 32'h40, 32'h0);
        bus_write(2'd2, 32'hA5A5_0001);
        bus_read(2'd0, r); chk("R5 full set", r & 32'h40, 32'h40);
        bus_write(2'd2, 32'hDEAD);             // full: ignored
        wait_prog(p0 + 1);
        bus_write(2'd2, 32'h0000_0002);
        wait_idle();
        chk("R6 prog count", n_prog, p0 + 2);
        chk("R5 first word", prog_log[p0 % 8], 32'hA5A5_0001);
        chk("R5 second word", prog_log[(p0 + 1) % 8], 32'h2);
        chk("R6 last prog addr", last_paddr, 32'hC01);
        bus_read(2'd1, r); chk("R6 addr incremented", r, 32'hC02);
        bus_read(2'd0, r); chk("R8 timeout end", r, 32'h0);
    endtask

    task automatic t_lock();
        logic [31:0] r;
        int e0 = n_erase, p0 = n_prog;
        page_lock[7] = 1'b1;
        bus_write(2'd1, 32'h3800);             // page 7
        bus_write(2'd0, 32'h1);
        wait_idle();
        bus_read(2'd0, r); chk("R7 erase abort", r, 32'h20);
        chk("R7 no erase", n_erase, e0);
        bus_write(2'd0, 32'h2);
        bus_read(2'd0, r); chk("R7 abort cleared on start", r & 32'h20, 32'h0);
        bus_write(2'd2, 32'h99);
        wait_idle();
        bus_read(2'd0, r); chk("R7 write abort", r, 32'h20);
        chk("R7 no prog", n_prog, p0);
        bus_write(2'd1, 32'h7F800);            // page 255
        bus_write(2'd0, 32'h1);
        wait_idle();
        bus_read(2'd0, r); chk("R7 top page blocked", r, 32'h20);
        bus_write(2'd0, 32'h201);
        wait_idle();
        bus_read(2'd0, r); chk("R7 top page enabled", r, 32'h200);
        chk("R7 top page erased", last_page, 32'd255);
    endtask

    task automatic t_chain();
        logic [31:0] r;
        int e0 = n_erase, p0 = n_prog;
        bus_write(2'd1, 32'h4000);             // page 8
        bus_write(2'd0, 32'h3);
        bus_write(2'd2, 32'h77);
        wait_idle();
        chk("R4 erase done", n_erase, e0 + 1);
        chk("R4 prog done", n_prog, p0 + 1);
        chk("R4 erase before prog", (erase_at < prog_at) ? 1 : 0, 32'd1);
        chk("R4 prog addr", last_paddr, 32'h1000);
        bus_write(2'd1, 32'h3800);             // locked page 7
        bus_write(2'd0, 32'h3);
        wait_idle();
        bus_read(2'd0, r); chk("R9 abort only from write", r, 32'h0);
    endtask

    task automatic t_info();
        logic [31:0] r;
        int e0 = n_erase;
        bus_write(2'd1, 32'h3800);
        bus_write(2'd0, 32'h101);
        wait_idle();
        chk("R12 info erase issued", n_erase, e0 + 1);
        chk("R12 info flag", last_info, 32'd1);
        bus_read(2'd0, r); chk("R12 no abort", r, 32'h100);
    endtask

    task automatic t_wrap();
        logic [31:0] r;
        bus_write(2'd1, 32'h7FFFC);
        bus_write(2'd0, 32'h202);
        bus_write(2'd2, 32'h5);
        wait_idle();
        chk("R6 wrap prog addr", last_paddr, 32'h1FFFF);
        bus_read(2'd1, r); chk("R6 wrap to zero", r, 32'h0);
    endtask

    task automatic t_cache();
        logic [31:0] r;
        bus_write(2'd0, 32'h8);
        bus_read(2'd0, r); chk("R11 mode unchanged", r & 32'hC, 32'h0);
        chk("R11 req", {cm_req, cm_target}, 32'h6);
        bus_write(2'd0, 32'hC);
        chk("R11 pending write ignored", cm_target, 32'h2);
        @(negedge clk); cm_ready = 1'b1;
        @(negedge clk); cm_ready = 1'b0;
        bus_read(2'd0, r); chk("R11 mode applied", r, 32'h8);
        chk("R11 req dropped", cm_req, 32'h0);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_addr();
        t_erase();
        t_write();
        t_lock();
        t_chain();
        t_info();
        t_wrap();
        t_cache();
        finished = 1;
        summary();
    end
endmodule